// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects an on-chip valid/ready request port to an external asynchronous static RAM of 128K words by 16 bits. Each request carries a read/write flag, a word address, write data and a per-byte lane mask. The controller turns each request into the active-low strobe sequence the memory needs and drives the data bus only when that is safe. Read requests return the sampled word on a one-cycle response pulse.

Every analog timing minimum of the memory is met by holding a phase for a fixed number of clock cycles. Each count is computed at elaboration from a clock-period parameter in picoseconds. The count is rounded up and is never less than one cycle. When idle, the memory is held deselected and in standby, and the data driver is off.

Before a write that follows a read, the controller waits a turnaround interval. This gives the memory time to release the bus before the controller drives it.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and in every idle cycle after it, chip select, write strobe, output enable and both byte enables are high (inactive), the data driver is off, and `req_ready` is high.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the operation has finished.
- R3: A write holds chip select and write strobe low and output enable high. It drives the data bus for the whole window. Byte enable bit 0 goes low when mask bit 0 is set and covers data bits 7:0. Byte enable bit 1 goes low when mask bit 1 is set and covers bits 15:8. The window lasts ceil(max(35 ns, 25 ns)/period) cycles, which is 9 cycles at the default 4000 ps.
- R4: A write lasts at least 45 ns in total. At 4000 ps, `req_ready` returns 12 cycles after acceptance. Address and write data stay unchanged through the cycle in which the write strobe rises.
- R5: A read holds chip select and output enable low and write strobe high, with byte enables taken from the mask as in R3. This lasts ceil(55 ns/period) cycles, which is 14 at the default. The bus is sampled on the clock edge that ends this window.
- R6: `rsp_valid` is a single-cycle pulse, given on the cycle after the sampling edge. `rsp_rdata` carries the sampled lanes, and any lane whose mask bit is clear reads as zero.
- R7: A write that directly follows a read first spends ceil(18 ns/period) cycles (5 at the default) with all strobes high and the driver off. The driver is never on while output enable is low, or within 18 ns after output enable rises.
- R8: A write with mask 00 keeps both byte enables high and leaves the memory contents unchanged.
- R9: A write that follows a write, and a read in any position, start with no turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low; bit 0 = low byte |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The embedded properties check the following on every cycle:
- the idle standby state,
- that the write strobe and output enable never overlap,
- that the driver is on throughout a write and off whenever output enable is low,
- that address and data are held past the end of a write,
- that the response is a single-cycle pulse with disabled lanes zeroed.

Other behaviours depend on analog time and on the memory's stored contents, so only the bench scenarios can show them. These are the nanosecond lengths of the write and read windows, the 18 ns release gap before driving after a read, lane-selective updates and the no-effect mask 00 write. The bench shows them against a timed memory model over a sweep of addresses and every mask value.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WREC   = 3'd3,
        ST_RACC   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lanes_on;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBES_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                        lanes_on: 1'b0, drive: 1'b0};

    // Memory timing minimums in nanoseconds
    localparam int unsigned T_WCYC_NS  = 45;
    localparam int unsigned T_WPW_NS   = 35;
    localparam int unsigned T_WSTB_NS  = 35;
    localparam int unsigned T_DSU_NS   = 25;
    localparam int unsigned T_RCYC_NS  = 55;
    localparam int unsigned T_ACC_NS   = 55;
    localparam int unsigned T_REL_NS   = 18;

    function automatic int unsigned cycles_for(int unsigned ns, int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(seq_state_e st);
        strobe_t s;
        s = STROBES_OFF;
        case (st)
            ST_WPULSE: begin
                s.ce_n     = 1'b0;
                s.we_n     = 1'b0;
                s.lanes_on = 1'b1;
                s.drive    = 1'b1;
            end
            ST_WREC:   s.drive = 1'b1;
            ST_RACC: begin
                s.ce_n     = 1'b0;
                s.oe_n     = 1'b0;
                s.lanes_on = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_unit.sv
module asram_lane_unit #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata
);
    logic [7:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_q[i] <= 8'h00;
            else if (capture)
                lane_q[i] <= mask[i] ? dq_i[i*8 +: 8] : 8'h00;
        end

        assign rdata[i*8 +: 8] = lane_q[i];

        // R6: a disabled lane returns zero
        p_lane_zero_r6: assert property (@(posedge clk) disable iff (rst)
            (capture && !mask[i]) |=> (rdata[i*8 +: 8] == 8'h00));

        // R6: response data changes only on a capture
        p_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !capture |=> $stable(rdata[i*8 +: 8]));
    end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned N_WE  = 9,
    parameter int unsigned N_REC = 3,
    parameter int unsigned N_RD  = 14,
    parameter int unsigned N_TA  = 5,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  logic             req_write,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             idle,
    output logic             capture,
    output strobe_t          strobes
);
    seq_state_e state_q, state_d;
    logic       rd_last_q, rd_last_d;
    strobe_t    strobes_q;

    always_comb begin
        state_d    = state_q;
        rd_last_d  = rd_last_q;
        timer_load = 1'b0;
        timer_val  = '0;
        capture    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    timer_load = 1'b1;
                    if (!req_write) begin
                        state_d   = ST_RACC;
                        timer_val = CNT_W'(N_RD - 1);
                        rd_last_d = 1'b1;
                    end else if (rd_last_q) begin
                        state_d   = ST_TURN;
                        timer_val = CNT_W'(N_TA - 1);
                    end else begin
                        state_d   = ST_WPULSE;
                        timer_val = CNT_W'(N_WE - 1);
                    end
                end
            end
            ST_TURN: begin
                if (timer_done) begin
                    state_d    = ST_WPULSE;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(N_WE - 1);
                    rd_last_d  = 1'b0;
                end
            end
            ST_WPULSE: begin
                if (timer_done) begin
                    state_d    = ST_WREC;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(N_REC - 1);
                end
            end
            ST_WREC: begin
                if (timer_done) state_d = ST_IDLE;
            end
            ST_RACC: begin
                if (timer_done) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rd_last_q <= 1'b0;
            strobes_q <= STROBES_OFF;
        end else begin
            state_q   <= state_d;
            rd_last_q <= rd_last_d;
            strobes_q <= strobes_for(state_d);
        end
    end

    assign idle    = (state_q == ST_IDLE);
    assign strobes = strobes_q;

    // R7: a write entered straight from idle never follows a read
    p_turn_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_IDLE && state_q == ST_WPULSE) |-> !$past(rd_last_q));

    // R5: the read window only closes through a capture
    p_read_ends_captured_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RACC && state_d != ST_RACC) |-> capture);

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned PERIOD_PS = 4000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_i
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned N_WE  = max_u(cycles_for(T_WPW_NS, PERIOD_PS),
                                    max_u(cycles_for(T_WSTB_NS, PERIOD_PS),
                                          cycles_for(T_DSU_NS, PERIOD_PS)));
    localparam int unsigned N_WC  = max_u(cycles_for(T_WCYC_NS, PERIOD_PS), N_WE + 1);
    localparam int unsigned N_REC = N_WC - N_WE;
    localparam int unsigned N_RD  = max_u(cycles_for(T_RCYC_NS, PERIOD_PS),
                                          cycles_for(T_ACC_NS, PERIOD_PS));
    localparam int unsigned N_TA  = cycles_for(T_REL_NS, PERIOD_PS);
    localparam int unsigned N_MAX = max_u(max_u(N_WE, N_REC), max_u(N_RD, N_TA));
    localparam int unsigned CNT_W = $clog2(N_MAX + 1);

    logic              fire;
    logic              idle;
    logic              capture;
    logic              timer_load;
    logic              timer_done;
    logic [CNT_W-1:0]  timer_val;
    strobe_t           strb;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              rsp_q;

    assign fire = req_valid && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= capture;
            if (fire) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
        end
    end

    asram_seq #(
        .N_WE (N_WE),
        .N_REC(N_REC),
        .N_RD (N_RD),
        .N_TA (N_TA),
        .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (fire),
        .req_write (req_write),
        .timer_done(timer_done),
        .timer_load(timer_load),
        .timer_val (timer_val),
        .idle      (idle),
        .capture   (capture),
        .strobes   (strb)
    );

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(timer_val),
        .done    (timer_done)
    );

    asram_lane_unit #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .mask   (mask_q),
        .dq_i   (mem_dq_i),
        .rdata  (rsp_rdata)
    );

    assign req_ready = idle;
    assign rsp_valid = rsp_q;
    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign mem_ce_n  = strb.ce_n;
    assign mem_we_n  = strb.we_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_dq_oe = strb.drive;
    assign mem_be_n  = ~(mask_q & {LANES{strb.lanes_on}});

    // R1: idle means deselected, standby and bus released
    p_idle_standby_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

    // R2: busy right after an accepted request
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3: write strobe and output enable never low together
    p_no_rw_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n || mem_oe_n));

    // R3: data driven throughout a write window
    p_write_drives_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    // R4: address steady while the memory is selected
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R4: data and address still held in the cycle the write strobe rises
    p_data_held_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

    // R7: never drive while the memory may drive
    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    // R6: response is a single-cycle pulse
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R5: a response follows a read window
    p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/asram_lane_ctrl_bench.sv
module asram_lane_ctrl_bench;
    // Time unit: one step = 0.5 ns; clock period 8 steps = 4 ns (250 MHz)
    localparam int unsigned PER_PS = 4000;
    localparam int HALF  = 4;
    localparam int STEPS = 2;  // steps per ns

    function automatic int cyc(int ns);
        return (ns * 1000 + PER_PS - 1) / PER_PS;
    endfunction

    localparam int N_WC = cyc(45);
    localparam int N_RD = cyc(55);
    localparam int N_TA = cyc(18);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = 16'hDEAD;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] sram    [logic [16:0]];
    logic [15:0] exp_mem [logic [16:0]];

    asram_lane_ctrl u_asram_lane_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    initial forever #HALF clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(logic [16:0] a);
        return sram.exists(a) ? sram[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] exp_word(logic [16:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    endfunction

    // Timed memory model, sampled between clock edges every 1 ns
    initial begin
        longint rd_start = 0, rd_end = -1000, wr_start = 0, wr_data_t = 0;
        bit rd_prev = 0, wr_prev = 0;
        logic [15:0] wr_data = '0;
        logic [1:0]  wr_lanes = '0;
        logic [16:0] wr_addr = '0;
        #1;
        forever begin
            longint now;
            bit rd_now, wr_now;
            now    = $time;
            rd_now = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
            wr_now = !mem_ce_n && !mem_we_n && (mem_be_n != 2'b11);
            if (mem_dq_oe && (rd_now || (now - rd_end) < 18 * STEPS))
                chk(1'b0, "R7 bus driven during memory release", 32'(now - rd_end), 32'(18 * STEPS));
            if (rd_now && !rd_prev) rd_start = now;
            if (!rd_now && rd_prev) begin
                rd_end = now;
                chk((now - rd_start) >= 55 * STEPS, "R5 read window length",
                    32'(now - rd_start), 32'(55 * STEPS));
            end
            if (wr_now && !wr_prev) begin
                wr_start  = now;
                wr_data_t = now;
            end
            if (wr_now) begin
                if (!mem_dq_oe) chk(1'b0, "R3 data not driven in write", 0, 1);
                if (wr_prev && mem_dq_o != wr_data) wr_data_t = now;
                wr_data  = mem_dq_o;
                wr_lanes = ~mem_be_n;
                wr_addr  = mem_addr;
            end
            if (!wr_now && wr_prev) begin
                logic [15:0] w;
                chk((now - wr_start) >= 35 * STEPS, "R3 write window length",
                    32'(now - wr_start), 32'(35 * STEPS));
                chk((now - wr_data_t) >= 25 * STEPS, "R3 data setup",
                    32'(now - wr_data_t), 32'(25 * STEPS));
                w = mem_word(wr_addr);
                if (wr_lanes[0]) w[7:0]  = wr_data[7:0];
                if (wr_lanes[1]) w[15:8] = wr_data[15:8];
                sram[wr_addr] = w;
            end
            if (rd_now && (now - rd_start) >= 55 * STEPS) begin
                logic [15:0] r;
                r = mem_word(mem_addr);
                mem_dq_i = {mem_be_n[1] ? 8'hFF : r[15:8], mem_be_n[0] ? 8'hFF : r[7:0]};
            end else begin
                mem_dq_i = 16'hDEAD;
            end
            rd_prev = rd_now;
            wr_prev = wr_now;
            #STEPS;
        end
    end

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, output int lat, output logic [15:0] rd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", 32'(req_ready), 0);
        lat = 1;
        rd  = '0;
        if (wr) begin
            while (!req_ready && lat < 300) begin @(negedge clk); lat++; end
        end else begin
            while (!rsp_valid && lat < 300) begin @(negedge clk); lat++; end
            rd = rsp_rdata;
            @(negedge clk);
            chk(!rsp_valid, "R6 single-cycle response", 32'(rsp_valid), 0);
        end
    endtask

    function automatic logic [16:0] addr_of(int i);
        return (i == 11) ? 17'h1FFFF : 17'(i * 11131);
    endfunction

    function automatic logic [15:0] pat(logic [16:0] a, int k);
        return 16'(32'(a) * 37 + k * 4099 + 32'h1234);
    endfunction

    function automatic logic [15:0] lane_sel(logic [15:0] v, logic [1:0] m);
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    task automatic exp_write(logic [16:0] a, logic [15:0] d, logic [1:0] m);
        logic [15:0] w;
        w = exp_word(a);
        if (m[0]) w[7:0]  = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        exp_mem[a] = w;
    endtask

    initial begin
        int lat;
        logic [15:0] rd;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
            {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h7);
        chk(mem_be_n == 2'b11 && !mem_dq_oe, "R1 lanes off and driver off in reset",
            {29'd0, mem_be_n, mem_dq_oe}, 32'h6);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && mem_ce_n, "R1 idle after reset",
            {30'd0, req_ready, rsp_valid}, 32'h2);

        // Full-word fill, write after write: no turnaround (R4, R9)
        for (int i = 0; i < 12; i++) begin
            do_op(1'b1, addr_of(i), pat(addr_of(i), 0), 2'b11, lat, rd);
            exp_write(addr_of(i), pat(addr_of(i), 0), 2'b11);
            chk(lat == N_WC + 1, "R4 R9 write cycle length", 32'(lat), 32'(N_WC + 1));
        end

        // Reads under every lane mask (R5, R6)
        for (int i = 0; i < 12; i++) begin
            for (int m = 0; m < 4; m++) begin
                do_op(1'b0, addr_of(i), 16'h0, 2'(m), lat, rd);
                chk(lat == N_RD + 1, "R5 read latency", 32'(lat), 32'(N_RD + 1));
                chk(rd == lane_sel(exp_word(addr_of(i)), 2'(m)), "R6 masked read data",
                    32'(rd), 32'(lane_sel(exp_word(addr_of(i)), 2'(m))));
            end
        end

        // Partial writes after reads: turnaround, lane selectivity, mask 00 (R3, R7, R8)
        for (int i = 0; i < 12; i++) begin
            for (int m = 0; m < 4; m++) begin
                do_op(1'b1, addr_of(i), pat(addr_of(i), m + 1), 2'(m), lat, rd);
                exp_write(addr_of(i), pat(addr_of(i), m + 1), 2'(m));
                chk(lat == N_TA + N_WC + 1, "R7 write after read turnaround",
                    32'(lat), 32'(N_TA + N_WC + 1));
                do_op(1'b0, addr_of(i), 16'h0, 2'b11, lat, rd);
                chk(rd == exp_word(addr_of(i)), (m == 0) ? "R8 mask 00 write no effect"
                                                         : "R3 lane write result",
                    32'(rd), 32'(exp_word(addr_of(i))));
            end
        end

        // Write after read then write after write (R7, R9)
        do_op(1'b1, 17'h00005, 16'hA55A, 2'b11, lat, rd);
        exp_write(17'h00005, 16'hA55A, 2'b11);
        chk(lat == N_TA + N_WC + 1, "R7 turnaround before write", 32'(lat), 32'(N_TA + N_WC + 1));
        do_op(1'b1, 17'h00006, 16'h5AA5, 2'b10, lat, rd);
        exp_write(17'h00006, 16'h5AA5, 2'b10);
        chk(lat == N_WC + 1, "R9 no turnaround after write", 32'(lat), 32'(N_WC + 1));
        do_op(1'b0, 17'h00006, 16'h0, 2'b11, lat, rd);
        chk(rd == exp_word(17'h00006), "R3 high lane only write", 32'(rd), 32'(exp_word(17'h00006)));
        @(negedge clk);
        chk(req_ready && mem_ce_n && mem_be_n == 2'b11 && !mem_dq_oe, "R1 idle standby at end",
            {29'd0, mem_ce_n, mem_be_n}, 32'h7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule